// File: doc/BRIEF.md
# Turbo Decoder Input Depuncturer

This block rebuilds the full-length soft input of a turbo decoder from the punctured stream that actually arrives over the channel. The transmitter forces some first-parity bits to zero by adding insertion bits, and then removes the insertion bits and every parity bit they cause. The receiver knows where these positions are. For each of the Z positions of a frame, the block produces one triple: systematic, first parity and second parity. Each soft value that was transmitted is taken from the input stream. Each removed value is filled in locally.

The forced positions follow a fixed repeating pattern. Where a position's first parity is a known zero, the block emits the largest positive LLR. The insertion bit's own systematic value is unknown, so it gets a zero LLR. The second parity is computed over interleaved data, so its punctured positions do not follow the simple pattern. A per-position flag memory marks them. During setup the interleaver mapping is written into this memory, one entry per interleaved position, and the block classifies each source index as it is written. The decoder itself lies outside this block.

Top module: `llr_depuncture`

## Requirements
- R1: A frame has Z positions, numbered 0 to Z-1. For each position exactly one triple is emitted, in ascending order, with `out_pos` giving the position number. `out_last` is high only with position Z-1, and the next frame starts again at 0.
- R2: Position p is forced when bit (p mod PERIOD) of `PAT_MASK` is set (by default PERIOD is 16 and the offsets are 0, 3, 4, 8 and 11) and p < Z - TAIL_LEN. Matching positions inside the trailing TAIL_LEN positions are not forced.
- R3: At a forced position, `out_p1` is +127 and `out_sys` is 0. LLRs are 8-bit two's complement, and a positive value means bit zero. Neither slot takes an input sample.
- R4: `out_p2` at position p is 0 and takes no sample when the p2 flag of p is set. Otherwise it takes one sample.
- R5: A setup write with `cfg_we` high, `cfg_idx` = p and `cfg_src` = the interleaver source index of p sets the p2 flag of p to the R2 classification of `cfg_src`. Reset clears all flags.
- R6: Unpunctured slots take samples in the order systematic, parity 1, parity 2 within each position. One sample is taken per cycle with `in_valid` and `in_ready` both high. `in_ready` is low while a punctured slot is being filled. `in_llr` has no effect unless it is accepted.
- R7: During reset, `out_valid` is low. The first triple after reset is position 0.
- R8: `out_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Setup write strobe for the p2 flag memory |
| cfg_idx | input | IW | Interleaved position being written |
| cfg_src | input | IW | Natural-order source index of that position |
| in_valid | input | 1 | Received sample present |
| in_ready | output | 1 | Current slot wants a sample |
| in_llr | input | LLR_W | Received soft value |
| out_valid | output | 1 | Triple present for one cycle |
| out_pos | output | IW | Position number of the triple |
| out_sys | output | LLR_W | Systematic LLR |
| out_p1 | output | LLR_W | First-parity LLR |
| out_p2 | output | LLR_W | Second-parity LLR |
| out_last | output | 1 | Triple is the last position of the frame |

## Verification
In one cycle, the slot that closes a position can do three things together: accept a sample, load the output triple, and wrap the position counter back to zero at a frame boundary. This case is driven by sending two frames back to back with `in_valid` held high. Other frames are sent with random input gaps. The positions, frame-end marks and fill values are compared against a queue model built from the requirements. A second case is a setup rewrite of the mapping while the sequencer is stalled waiting for a sample. It is judged by the triples of the following frame.

// File: rtl/dpf_pkg.sv
package dpf_pkg;
   typedef enum logic [1:0] {
      SLOT_SYS = 2'd0,
      SLOT_P1  = 2'd1,
      SLOT_P2  = 2'd2
   } slot_e;
endpackage

// File: rtl/dpf_pos_class.sv
// Classifies a natural-order index as a forced (insertion) position.
module dpf_pos_class #(
   parameter int unsigned Z        = 2192,
   parameter int unsigned TAIL_LEN = 5,
   parameter int unsigned PERIOD   = 16,
   parameter logic [PERIOD-1:0] PAT_MASK = 16'h0919,
   parameter int unsigned IW       = $clog2(Z)
) (
   input  logic [IW-1:0] idx,
   output logic          forced
);
   localparam int unsigned     PW         = $clog2(PERIOD);
   localparam logic [IW-1:0]   OPEN_LIMIT = IW'(Z - TAIL_LEN);

   logic [PW-1:0] phase;

   generate
      if ((PERIOD & (PERIOD - 1)) == 0) begin : g_pow2
         assign phase = idx[PW-1:0];
      end else begin : g_mod
         assign phase = PW'(32'(idx) % PERIOD);
      end
   endgenerate

   assign forced = PAT_MASK[phase] && (idx < OPEN_LIMIT);
endmodule

// File: rtl/dpf_p2_flags.sv
// One flag per interleaved position: set when the second parity there is punctured.
module dpf_p2_flags #(
   parameter int unsigned Z  = 2192,
   parameter int unsigned IW = $clog2(Z)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [IW-1:0] widx,
   input  logic          wval,
   input  logic [IW-1:0] ridx,
   output logic          rflag
);
   localparam logic [IW-1:0] TOP_IDX = IW'(Z - 1);

   logic [Z-1:0] mem;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mem <= '0;
      else if (we && (widx <= TOP_IDX))
         mem[widx] <= wval;
   end

   assign rflag = (ridx <= TOP_IDX) ? mem[ridx] : 1'b0;

   // R5: a write is visible at the read port on the next cycle
   a_r5_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (widx <= TOP_IDX) && (ridx == widx)) |=>
         ($stable(ridx) -> (rflag == $past(wval))));
endmodule

// File: rtl/dpf_sequencer.sv
// Walks slots sys/p1/p2 of each position, fills punctured slots, consumes the rest.
module dpf_sequencer
   import dpf_pkg::*;
#(
   parameter int unsigned Z     = 2192,
   parameter int unsigned LLR_W = 8,
   parameter int unsigned IW    = $clog2(Z)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             forced,
   input  logic             p2_punct,
   input  logic             in_valid,
   input  logic [LLR_W-1:0] in_llr,
   output logic             in_ready,
   output logic [IW-1:0]    pos,
   output logic             out_valid,
   output logic [IW-1:0]    out_pos,
   output logic [LLR_W-1:0] out_sys,
   output logic [LLR_W-1:0] out_p1,
   output logic [LLR_W-1:0] out_p2,
   output logic             out_last
);
   localparam logic [LLR_W-1:0] KNOWN_ZERO = {1'b0, {(LLR_W-1){1'b1}}};
   localparam logic [IW-1:0]    LAST_POS   = IW'(Z - 1);

   slot_e            slot_q;
   logic [IW-1:0]    pos_q;
   logic [LLR_W-1:0] sys_q, p1_q;
   logic             cur_punct, adv, at_last;
   logic [LLR_W-1:0] slot_val;

   always_comb begin
      cur_punct = (slot_q == SLOT_P2) ? p2_punct : forced;
      if (cur_punct)
         slot_val = (slot_q == SLOT_P1) ? KNOWN_ZERO : '0;
      else
         slot_val = in_llr;
      adv     = cur_punct || in_valid;
      at_last = (pos_q == LAST_POS);
   end

   assign in_ready = !cur_punct;
   assign pos      = pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q    <= SLOT_SYS;
         pos_q     <= '0;
         sys_q     <= '0;
         p1_q      <= '0;
         out_valid <= 1'b0;
         out_pos   <= '0;
         out_sys   <= '0;
         out_p1    <= '0;
         out_p2    <= '0;
         out_last  <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         if (adv) begin
            unique case (slot_q)
               SLOT_SYS: begin
                  sys_q  <= slot_val;
                  slot_q <= SLOT_P1;
               end
               SLOT_P1: begin
                  p1_q   <= slot_val;
                  slot_q <= SLOT_P2;
               end
               default: begin
                  out_valid <= 1'b1;
                  out_pos   <= pos_q;
                  out_sys   <= sys_q;
                  out_p1    <= p1_q;
                  out_p2    <= slot_val;
                  out_last  <= at_last;
                  pos_q     <= at_last ? '0 : pos_q + 1'b1;
                  slot_q    <= SLOT_SYS;
               end
            endcase
         end
      end
   end

   // R3: forced systematic slot becomes zero, forced parity-1 slot becomes +max
   a_r3_sys_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_q == SLOT_SYS && forced) |=> (sys_q == '0));
   a_r3_p1_known: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_q == SLOT_P1 && forced) |=> (p1_q == KNOWN_ZERO));
   // R4: punctured second parity closes the position with a zero value
   a_r4_p2_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_q == SLOT_P2 && p2_punct) |=> (out_valid && out_p2 == '0));
   // R6: an unpunctured slot holds until a sample arrives
   a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !in_valid) |=> ($stable(slot_q) && $stable(pos_q)));
   // R8: triples never appear on two consecutive cycles
   a_r8_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);
   // R1: frame-end mark only on the final position
   a_r1_last_pos: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_last) |-> (out_pos == LAST_POS));
endmodule

// File: rtl/llr_depuncture.sv
module llr_depuncture
   import dpf_pkg::*;
#(
   parameter int unsigned Z        = 2192,
   parameter int unsigned TAIL_LEN = 5,
   parameter int unsigned PERIOD   = 16,
   parameter logic [PERIOD-1:0] PAT_MASK = 16'h0919,
   parameter int unsigned LLR_W    = 8,
   localparam int unsigned IW      = $clog2(Z)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [IW-1:0]    cfg_idx,
   input  logic [IW-1:0]    cfg_src,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [LLR_W-1:0] in_llr,
   output logic             out_valid,
   output logic [IW-1:0]    out_pos,
   output logic [LLR_W-1:0] out_sys,
   output logic [LLR_W-1:0] out_p1,
   output logic [LLR_W-1:0] out_p2,
   output logic             out_last
);
   initial begin
      a_cfg_tail: assert (Z > TAIL_LEN) else $error("TAIL_LEN must be below Z");
      a_cfg_period: assert (PERIOD >= 2 && $clog2(PERIOD) <= IW)
         else $error("PERIOD out of range");
      a_cfg_llr: assert (LLR_W >= 2) else $error("LLR_W too small");
   end

   logic [IW-1:0] cur_pos;
   logic          cur_forced, src_forced, p2_flag;

   dpf_pos_class #(.Z(Z), .TAIL_LEN(TAIL_LEN), .PERIOD(PERIOD),
                   .PAT_MASK(PAT_MASK), .IW(IW)) u_cls_pos (
      .idx    (cur_pos),
      .forced (cur_forced)
   );

   dpf_pos_class #(.Z(Z), .TAIL_LEN(TAIL_LEN), .PERIOD(PERIOD),
                   .PAT_MASK(PAT_MASK), .IW(IW)) u_cls_src (
      .idx    (cfg_src),
      .forced (src_forced)
   );

   dpf_p2_flags #(.Z(Z), .IW(IW)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .widx  (cfg_idx),
      .wval  (src_forced),
      .ridx  (cur_pos),
      .rflag (p2_flag)
   );

   dpf_sequencer #(.Z(Z), .LLR_W(LLR_W), .IW(IW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .forced    (cur_forced),
      .p2_punct  (p2_flag),
      .in_valid  (in_valid),
      .in_llr    (in_llr),
      .in_ready  (in_ready),
      .pos       (cur_pos),
      .out_valid (out_valid),
      .out_pos   (out_pos),
      .out_sys   (out_sys),
      .out_p1    (out_p1),
      .out_p2    (out_p2),
      .out_last  (out_last)
   );
endmodule

// File: tb/llr_depuncture_tb_top.sv
module llr_depuncture_tb_top;
   localparam int Z    = 64;
   localparam int TAIL = 5;
   localparam int IW   = 6;
   localparam logic [15:0] MASK = 16'h0919;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n, cfg_we, in_valid, in_ready, out_valid, out_last;
   logic [IW-1:0] cfg_idx, cfg_src, out_pos;
   logic [7:0]    in_llr, out_sys, out_p1, out_p2;

   llr_depuncture #(.Z(Z), .TAIL_LEN(TAIL), .PERIOD(16), .PAT_MASK(MASK), .LLR_W(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_src(cfg_src),
      .in_valid(in_valid), .in_ready(in_ready), .in_llr(in_llr),
      .out_valid(out_valid), .out_pos(out_pos), .out_sys(out_sys), .out_p1(out_p1),
      .out_p2(out_p2), .out_last(out_last)
   );

   int checks = 0;
   int errors = 0;
   int outs   = 0;
   int gap_pct = 0;
   int frame_id = 0;
   bit prev_ov = 1'b0;
   bit mdl_flag [Z];
   logic [7:0]  samp_q [$];
   logic [31:0] exp_q  [$];

   // R2: forced when the pattern bit is set and the position lies outside the tail
   function automatic bit is_forced(int p);
      return (MASK[p % 16] == 1'b1) && (p < Z - TAIL);
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic build_frame();
      for (int p = 0; p < Z; p++) begin
         logic [7:0] s, a, b;
         if (is_forced(p)) s = 8'h00;
         else begin s = 8'($urandom); samp_q.push_back(s); end
         if (is_forced(p)) a = 8'h7F;
         else begin a = 8'($urandom); samp_q.push_back(a); end
         if (mdl_flag[p]) b = 8'h00;
         else begin b = 8'($urandom); samp_q.push_back(b); end
         exp_q.push_back({8'(p), s, a, b});
      end
   endtask

   task automatic drive();
      while (samp_q.size() > 0) begin
         bit v, r;
         @(negedge clk);
         v = (($urandom % 100) >= gap_pct);
         in_valid = v;
         in_llr   = v ? samp_q[0] : 8'hA5;
         r = in_ready;
         @(posedge clk);
         if (v && r) void'(samp_q.pop_front());
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() > 0) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   // R5: load the flag memory from an interleaver mapping src = (mul*i + add) mod Z
   task automatic cfg_map(int mul, int add);
      for (int i = 0; i < Z; i++) begin
         int src;
         src = (mul * i + add) % Z;
         @(negedge clk);
         cfg_we  = 1'b1;
         cfg_idx = IW'(i);
         cfg_src = IW'(src);
         mdl_flag[i] = is_forced(src);
      end
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) begin
            chk("R8", "back-to-back out_valid", 32'(prev_ov), 32'd0);
            outs++;
            if (exp_q.size() == 0) begin
               checks++; errors++;
               $display("FAIL R1 unexpected triple actual=%0h expected=none", out_pos);
            end else begin
               logic [31:0] e;
               int p;
               string t13, t1, t2;
               e = exp_q.pop_front();
               p = int'(e[31:24]);
               t13 = is_forced(p) ? "R3" : ((MASK[p % 16] == 1'b1) ? "R2" : "R6");
               t1  = "R1";
               t2  = (frame_id == 0) ? "R5" : "R4";
               chk(t1, "position", 32'(out_pos), 32'(p));
               chk(t1, "last mark", 32'(out_last), 32'(p == Z - 1));
               chk(t13, "systematic", 32'(out_sys), 32'(e[23:16]));
               chk(t13, "parity1", 32'(out_p1), 32'(e[15:8]));
               chk(t2, "parity2", 32'(out_p2), 32'(e[7:0]));
            end
         end
         prev_ov = out_valid;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < Z; i++) mdl_flag[i] = 1'b0;
      rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_src = '0;
      in_valid = 1'b0; in_llr = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R7", "out_valid in reset", 32'(out_valid), 32'd0);
      chk("R3", "in_ready at forced position 0", 32'(in_ready), 32'd0);
      rst_n = 1'b1;

      // frame with reset flags (all p2 transmitted), random gaps
      frame_id = 0; gap_pct = 30;
      build_frame(); drive(); drain();

      // first mapping, gapped frame
      cfg_map(13, 5);
      frame_id = 1; gap_pct = 40;
      build_frame(); drive(); drain();

      // two frames back to back with no gaps: emission, acceptance and wrap coincide
      frame_id = 2; gap_pct = 0;
      build_frame(); build_frame(); drive(); drain();

      // rewrite mapping while stalled, heavy gaps
      cfg_map(21, 7);
      frame_id = 3; gap_pct = 60;
      build_frame(); drive(); drain();

      chk("R1", "total triples", 32'(outs), 32'(5 * Z));
      chk("R1", "pending expectations", 32'(exp_q.size()), 32'd0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule